// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block steers the four shared PCI interrupt pins (INTA, INTB, INTC, INTD) onto a sixteen-line ISA interrupt request vector. Software chooses the target for each pin through two configuration bytes. Each byte holds two four-bit routing fields. A field names the ISA IRQ number that the pin drives. A value of zero, or a number reserved for system devices, leaves the pin unconnected.

A third configuration byte does two things. It records the power-management trigger source. It can also raise a one-cycle software interrupt request on IRQ 10 or IRQ 15. The PCI pins are active low and level sensitive. Every routed output follows its pins through one register stage. Pins that share a target are merged by OR.

The routing bytes power up with non-zero contents. Even so, no pin reaches any ISA line until software has written the byte that holds its field.

Top module: `pci_irq_steer`

## Requirements
- R1: After reset `isaIrq` is 0 and `pmTrigByIrq` is 0. A pin stays disconnected until the routing byte that holds its field has been written, whatever value that byte held at reset.
- R2: Writing offset 0x43 routes INTA with bits 3:0 and INTB with bits 7:4. Routing takes effect for pin levels sampled at clock edges after the write.
- R3: Writing offset 0x44 routes INTC with bits 3:0 and INTD with bits 7:4. Routing takes effect for pin levels sampled at clock edges after the write.
- R4: A routing field of 0 connects its pin to no ISA line.
- R5: Routing field values 1, 2, 8 and 13 connect their pin to no ISA line. `isaIrq` bits 0, 1, 2, 8 and 13 are never driven by the block.
- R6: When several active pins are routed to the same ISA number, that `isaIrq` bit is the OR of those pins.
- R7: A pin is active while its input is low. The routed `isaIrq` bit reflects the pin level sampled at each rising edge, one cycle later, and drops after the pin returns high.
- R8: Writing offset 0x46 with bit 6 set raises exactly one cycle of request on `isaIrq[10]` when bit 7 is 0, or on `isaIrq[15]` when bit 7 is 1. The request appears in the cycle after the write and is ORed with any routed request.
- R9: Writing offset 0x46 with bit 6 clear raises no software request.
- R10: Every write to offset 0x46 loads its bit 7 into `pmTrigByIrq` (1 means IRQ trigger, 0 means SMI trigger). The output holds that value until the next write to 0x46.
- R11: Writes to any other offset change neither the routing nor `pmTrigByIrq`, and raise no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pciIntN | input | 4 | PCI interrupt pins, active low; bit 0 is INTA, bit 3 is INTD |
| cfgWrEn | input | 1 | Configuration write strobe, one cycle per write |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWrData | input | 8 | Configuration write data |
| isaIrq | output | 16 | Registered ISA IRQ request lines; bit n is IRQ n |
| pmTrigByIrq | output | 1 | Recorded power-management trigger source (1 IRQ, 0 SMI) |

## Verification
Some properties are checked on every clock. The reserved lines stay low. A software request lands on IRQ 10 or IRQ 15 according to the select bit. The trigger-source bit loads only on a write to 0x46 and is otherwise stable. A write to a foreign offset produces no strobe, and the output stays silent while no pin is armed.

Other behaviour only the bench scenarios can show. That covers the exact nibble-to-pin assignment in each routing byte and the effect of writing one routing byte but not the other. It also covers OR-merging of shared targets, level following over several cycles, and a software pulse overlapping a routed request on another line.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  // number of configuration bytes that carry routing fields
  localparam int ROUTE_REGS = 2;

  // decoded write strobes passed from control to datapath
  typedef struct packed {
    logic [ROUTE_REGS-1:0] loadReg;  // load routing byte n
    logic                  swLoad;   // write to the software-request byte
    logic                  swFire;   // software request asked for
    logic                  swSelHi;  // select bit carried with the write
  } pirqStrobe_t;

endpackage

// File: rtl/pirq_lane.sv
// Decodes one routing field into a one-hot request vector for one pin.
module pirq_lane #(
  parameter int FIELD_W = 4,
  parameter int IRQ_LINES = 16,
  parameter logic [IRQ_LINES-1:0] BLOCK_MASK = 16'h2107
) (
  input  logic [FIELD_W-1:0]   field,
  input  logic                 armed,
  input  logic                 pinActive,
  output logic [IRQ_LINES-1:0] laneVec
);

  always_comb begin
    laneVec = '0;
    if (armed && pinActive && !BLOCK_MASK[field]) begin
      laneVec[field] = 1'b1;
    end
  end

endmodule

// File: rtl/pirq_ctrl.sv
// Decodes configuration writes into strobes for the datapath.
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_ROUTE_LO = 8'h43,
  parameter logic [ADDR_W-1:0] ADDR_ROUTE_HI = 8'h44,
  parameter logic [ADDR_W-1:0] ADDR_SW = 8'h46,
  parameter int FIRE_BIT = 6,
  parameter int SEL_BIT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  output pirqStrobe_t       strobe
);

  logic hitLo;
  logic hitHi;
  logic hitSw;

  assign hitLo = cfgWrEn && (cfgAddr == ADDR_ROUTE_LO);
  assign hitHi = cfgWrEn && (cfgAddr == ADDR_ROUTE_HI);
  assign hitSw = cfgWrEn && (cfgAddr == ADDR_SW);

  always_comb begin
    strobe = '0;
    strobe.loadReg[0] = hitLo;
    strobe.loadReg[ROUTE_REGS-1] = hitHi;
    strobe.swLoad = hitSw;
    strobe.swFire = hitSw && cfgWrData[FIRE_BIT];
    strobe.swSelHi = hitSw && cfgWrData[SEL_BIT];
  end

  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr != ADDR_ROUTE_LO && cfgAddr != ADDR_ROUTE_HI && cfgAddr != ADDR_SW)
      |-> (strobe == '0)); // R11
  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadReg, strobe.swLoad})); // R2 R3
  AST_FIRE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.swFire || strobe.swSelHi) |-> strobe.swLoad); // R9

endmodule

// File: rtl/pirq_datapath.sv
// Holds routing state, merges pin requests and the software pulse.
module pirq_datapath
  import pirq_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int FIELD_W = 4,
  parameter int DATA_W = 8,
  parameter int SW_IRQ_LO = 10,
  parameter int SW_IRQ_HI = 15,
  parameter logic [2**FIELD_W-1:0] RESERVED_MASK = 16'h2106,
  parameter logic [NUM_PINS*FIELD_W-1:0] RESET_ROUTE = 16'hBC9A
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PINS-1:0]    pciIntN,
  input  logic [DATA_W-1:0]      wrByte,
  input  pirqStrobe_t            strobe,
  output logic [2**FIELD_W-1:0]  isaIrq,
  output logic                   pmTrigByIrq
);

  localparam int IRQ_LINES = 2**FIELD_W;
  localparam int PINS_PER_REG = DATA_W / FIELD_W;
  // field value zero never connects, on top of the reserved lines
  localparam logic [IRQ_LINES-1:0] BLOCK_MASK = RESERVED_MASK | IRQ_LINES'(1);

  logic [NUM_PINS-1:0][FIELD_W-1:0]   routeField;
  logic [NUM_PINS-1:0]                routeArmed;
  logic [NUM_PINS-1:0][IRQ_LINES-1:0] laneVec;
  logic [IRQ_LINES-1:0]               routedAll;
  logic [IRQ_LINES-1:0]               swVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        routeField[p] <= RESET_ROUTE[p*FIELD_W +: FIELD_W];
        routeArmed[p] <= 1'b0;
      end
    end else begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (strobe.loadReg[p / PINS_PER_REG]) begin
          routeField[p] <= wrByte[(p % PINS_PER_REG)*FIELD_W +: FIELD_W];
          routeArmed[p] <= 1'b1;
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : gLane
    pirq_lane #(
      .FIELD_W(FIELD_W),
      .IRQ_LINES(IRQ_LINES),
      .BLOCK_MASK(BLOCK_MASK)
    ) uLane (
      .field(routeField[p]),
      .armed(routeArmed[p]),
      .pinActive(!pciIntN[p]),
      .laneVec(laneVec[p])
    );
  end

  always_comb begin
    routedAll = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      routedAll = routedAll | laneVec[p];
    end
  end

  always_comb begin
    swVec = '0;
    if (strobe.swFire) begin
      if (strobe.swSelHi) swVec[SW_IRQ_HI] = 1'b1;
      else                swVec[SW_IRQ_LO] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isaIrq <= '0;
      pmTrigByIrq <= 1'b0;
    end else begin
      isaIrq <= routedAll | swVec;
      if (strobe.swLoad) pmTrigByIrq <= strobe.swSelHi;
    end
  end

  AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ((isaIrq & BLOCK_MASK) == '0)); // R5
  AST_SW_LOW_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.swFire && !strobe.swSelHi) |=> isaIrq[SW_IRQ_LO]); // R8
  AST_SW_HIGH_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.swFire && strobe.swSelHi) |=> isaIrq[SW_IRQ_HI]); // R8
  AST_PM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swLoad |=> (pmTrigByIrq == $past(strobe.swSelHi))); // R10
  AST_PM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.swLoad |=> $stable(pmTrigByIrq)); // R10
  AST_UNARMED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (routeArmed == '0 && !strobe.swFire) |=> (isaIrq == '0)); // R1

endmodule

// File: rtl/pci_irq_steer.sv
module pci_irq_steer
  import pirq_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int FIELD_W = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_ROUTE_LO = 8'h43,
  parameter logic [ADDR_W-1:0] ADDR_ROUTE_HI = 8'h44,
  parameter logic [ADDR_W-1:0] ADDR_SW = 8'h46,
  parameter int SW_IRQ_LO = 10,
  parameter int SW_IRQ_HI = 15
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pciIntN,
  input  logic                  cfgWrEn,
  input  logic [ADDR_W-1:0]     cfgAddr,
  input  logic [DATA_W-1:0]     cfgWrData,
  output logic [2**FIELD_W-1:0] isaIrq,
  output logic                  pmTrigByIrq
);

  pirqStrobe_t strobe;

  pirq_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .ADDR_ROUTE_LO(ADDR_ROUTE_LO),
    .ADDR_ROUTE_HI(ADDR_ROUTE_HI),
    .ADDR_SW(ADDR_SW),
    .FIRE_BIT(6),
    .SEL_BIT(7)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData),
    .strobe(strobe)
  );

  pirq_datapath #(
    .NUM_PINS(NUM_PINS),
    .FIELD_W(FIELD_W),
    .DATA_W(DATA_W),
    .SW_IRQ_LO(SW_IRQ_LO),
    .SW_IRQ_HI(SW_IRQ_HI),
    .RESERVED_MASK(16'h2106),
    .RESET_ROUTE(16'hBC9A)
  ) uData (
    .clk(clk),
    .rstN(rstN),
    .pciIntN(pciIntN),
    .wrByte(cfgWrData),
    .strobe(strobe),
    .isaIrq(isaIrq),
    .pmTrigByIrq(pmTrigByIrq)
  );

endmodule

// File: tb/sim_pci_irq_steer.sv
`timescale 1ns/1ps
module sim_pci_irq_steer;

  typedef struct {
    logic [15:0] expIrq;
    logic        expPm;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  pciIntN = 4'hF;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgAddr = 8'h00;
  logic [7:0]  cfgWrData = 8'h00;
  logic [15:0] isaIrq;
  logic        pmTrigByIrq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  item_t expQ[$];
  item_t cur;

  // reference state built from the requirements
  logic [3:0] mField [4];
  logic [3:0] mArmed;
  logic       mPm;

  always #10 clk = ~clk;

  pci_irq_steer u0 (
    .clk(clk), .rstN(rstN), .pciIntN(pciIntN), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .isaIrq(isaIrq), .pmTrigByIrq(pmTrigByIrq)
  );

  function automatic logic [15:0] modelRoute(input logic [3:0] pinsN);
    logic [15:0] v = '0;
    for (int p = 0; p < 4; p++) begin
      logic [3:0] f = mField[p];
      if (mArmed[p] && !pinsN[p] && f != 0 && f != 1 && f != 2 && f != 8 && f != 13)
        v[f] = 1'b1;
    end
    return v;
  endfunction

  // driver: applies one cycle of stimulus and queues what must follow
  task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input logic [3:0] pins, input string tag);
    item_t it;
    @(negedge clk);
    cfgWrEn = we; cfgAddr = a; cfgWrData = d; pciIntN = pins;
    it.expIrq = modelRoute(pins);
    if (we && a == 8'h46 && d[6]) it.expIrq[d[7] ? 15 : 10] = 1'b1;
    if (we && a == 8'h43) begin
      mField[0] = d[3:0]; mField[1] = d[7:4]; mArmed[1:0] = 2'b11;
    end
    if (we && a == 8'h44) begin
      mField[2] = d[3:0]; mField[3] = d[7:4]; mArmed[3:2] = 2'b11;
    end
    if (we && a == 8'h46) mPm = d[7];
    it.expPm = mPm;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic doReset();
    item_t it;
    @(negedge clk);
    rstN = 1'b0; cfgWrEn = 1'b0; pciIntN = 4'h0;
    mArmed = '0; mPm = 1'b0;
    for (int p = 0; p < 4; p++) mField[p] = '0;
    it.expIrq = '0; it.expPm = 1'b0; it.tag = "R1";
    expQ.push_back(it);
    @(negedge clk);
    rstN = 1'b1; pciIntN = 4'hF;
  endtask

  // monitor: compares one queued item per cycle, after the edge settles
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      cur = expQ.pop_front();
      checks++;
      if (isaIrq !== cur.expIrq || pmTrigByIrq !== cur.expPm) begin
        fails++;
        $display("FAIL %s: isaIrq=%h pm=%b expected isaIrq=%h pm=%b",
                 cur.tag, isaIrq, pmTrigByIrq, cur.expIrq, cur.expPm);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: reset contents are not applied
    step(0, 8'h00, 8'h00, 4'h0, "R1");
    step(0, 8'h00, 8'h00, 4'h0, "R1");
    // R2: low nibble INTA, high nibble INTB
    step(1, 8'h43, 8'h5B, 4'hF, "R2");
    step(0, 8'h00, 8'h00, 4'hE, "R2");
    step(0, 8'h00, 8'h00, 4'hD, "R2");
    // R1: byte 0x44 still unwritten, INTC and INTD silent
    step(0, 8'h00, 8'h00, 4'h3, "R1");
    // R3: low nibble INTC, high nibble INTD
    step(1, 8'h44, 8'h97, 4'hF, "R3");
    step(0, 8'h00, 8'h00, 4'hB, "R3");
    step(0, 8'h00, 8'h00, 4'h7, "R3");
    step(0, 8'h00, 8'h00, 4'h0, "R3");
    // R6: shared target
    step(1, 8'h43, 8'h77, 4'hF, "R6");
    step(1, 8'h44, 8'h37, 4'hF, "R6");
    step(0, 8'h00, 8'h00, 4'hE, "R6");
    step(0, 8'h00, 8'h00, 4'hD, "R6");
    step(0, 8'h00, 8'h00, 4'hA, "R6");
    step(0, 8'h00, 8'h00, 4'h0, "R6");
    // R7: level following
    for (int i = 0; i < 4; i++) step(0, 8'h00, 8'h00, 4'hE, "R7");
    step(0, 8'h00, 8'h00, 4'hF, "R7");
    step(0, 8'h00, 8'h00, 4'hF, "R7");
    // R4: zero field
    step(1, 8'h43, 8'h0E, 4'hF, "R4");
    step(0, 8'h00, 8'h00, 4'hD, "R4");
    step(0, 8'h00, 8'h00, 4'hE, "R4");
    // R5: reserved field values
    step(1, 8'h44, 8'h21, 4'hF, "R5");
    step(0, 8'h00, 8'h00, 4'h3, "R5");
    step(1, 8'h44, 8'hD8, 4'hF, "R5");
    step(0, 8'h00, 8'h00, 4'h3, "R5");
    // R8: software pulse on each line, single cycle, ORed with routing
    step(1, 8'h46, 8'h40, 4'hF, "R8");
    step(0, 8'h00, 8'h00, 4'hF, "R8");
    step(1, 8'h46, 8'hC0, 4'hF, "R8");
    step(0, 8'h00, 8'h00, 4'hF, "R8");
    step(1, 8'h46, 8'h40, 4'hE, "R8");
    step(0, 8'h00, 8'h00, 4'hE, "R8");
    // R9 and R10: no pulse without bit 6, bit 7 recorded
    step(1, 8'h46, 8'h80, 4'hF, "R9");
    step(0, 8'h00, 8'h00, 4'hF, "R10");
    step(1, 8'h46, 8'h00, 4'hF, "R10");
    step(0, 8'h00, 8'h00, 4'hF, "R10");
    // R11: foreign offsets ignored
    step(1, 8'h45, 8'hFF, 4'hF, "R11");
    step(1, 8'h42, 8'h00, 4'hF, "R11");
    step(1, 8'h47, 8'hC0, 4'hF, "R11");
    step(0, 8'h00, 8'h00, 4'hE, "R11");
    step(0, 8'h00, 8'h00, 4'hF, "R11");
    // R1: second reset drops all routing
    doReset();
    step(0, 8'h00, 8'h00, 4'h0, "R1");
    step(0, 8'h00, 8'h00, 4'hF, "R1");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule